// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is a two-wire serial target that keeps a bank of six 8-bit configuration bytes for the clock control logic around it. A controller updates the bank with a block write. The write carries the target address, then a command byte and a count byte, and both of those are thrown away. Data bytes follow and always fill the bank from byte 0 upward. A block read returns a count byte first and then the bank contents in ascending order. The bank is always visible on a flat output bus, so the clock control logic never has to wait for the serial side.

SCL and SDA are sampled in the system clock domain through synchronizer stages, and their edges are detected there. The target never stretches SCL. It drives SDA only by pulling it low, and that pull-down is exposed as an enable so the pad logic can build the open-drain driver. The serial bit rate has to stay well below the system clock rate: standard-mode rates of 100 kbit/s or less, against a system clock of tens of MHz.

Top module: `cfg_bank_target`

## Requirements
- R1: The target acknowledges the address byte 0xD2 (write) and the address byte 0xD3 (read) by pulling SDA low during the ninth SCL pulse. Any other address byte gets no acknowledge, and the target ignores the bus until the next start condition.
- R2: In a write, the first two bytes after the address are acknowledged and then discarded. A write that ends after those two bytes leaves every configuration byte unchanged.
- R3: Each later data byte of a write goes to the next configuration byte, beginning at byte 0. A stop condition after any complete byte ends the write, and the bytes that were not reached keep their values. Byte i appears on cfgBytes[8*i+7:8*i].
- R4: Every byte received after a matching address is acknowledged. This includes data bytes past byte 5, which are discarded without changing the bank.
- R5: In a read, the target first sends the byte count 6 and then bytes 0 through 5, MSB first. Each data bit is held steady while SCL is high.
- R6: A not-acknowledge from the controller after a read byte ends the read. SDA is released and stays released until the next start condition.
- R7: After reset, byte 0 is 0x0C (bits 3 and 2 set) and bytes 1 to 5 are 0xFF.
- R8: The target changes its SDA pull-down only while SCL is low, unless a start or stop condition forces a release.
- R9: A repeated start in the middle of a transfer begins a fresh address phase. Write data after it lands again at byte 0, and a read after it begins again with the count byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaDriveLow | output | 1 | When high, the pad pulls SDA low |
| cfgBytes | output | 48 | Configuration bank, byte i on bits 8*i+7:8*i |

## Verification
A wrong bit count or a wrong state in the receive path shows up at the ports within one byte time. The acknowledge either goes missing or arrives one SCL pulse off, so the controller reads SDA high where low was due. A write or read pointer that slips puts a value in the wrong bank position. After a write, that shows on cfgBytes as soon as the stop condition arrives. In a read, it shows as a byte-order miscompare on the very next byte. A pull-down that is not released after a not-acknowledge or a mismatched address shows as SDA stuck low on the next SCL pulse that the controller clocks.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } busState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clearPtrs;  // start condition: rewind both pointers
    logic sampleBit;  // shift SDA into the receive register
    logic storeByte;  // completed data byte, write at the write pointer
    logic loadTx;     // load the transmit register, advance the read pointer
    logic shiftTx;    // move the next transmit bit to the MSB
  } dpStrobe_t;

  function automatic logic [7:0] resetByte(input int idx);
    return (idx == 0) ? 8'h0C : 8'hFF;
  endfunction

endpackage

// File: rtl/cfg_bank_sync.sv
module cfg_bank_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclHigh,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startCond,
  output logic stopCond
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
      for (int i = 1; i < STAGES; i++) begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclHigh   = sclPipe[STAGES-1];
  assign sdaBit    = sdaPipe[STAGES-1];
  assign sclRise   = sclHigh && !sclPrev;
  assign sclFall   = !sclHigh && sclPrev;
  assign startCond = sclHigh && sclPrev && sdaPrev && !sdaBit;
  assign stopCond  = sclHigh && sclPrev && !sdaPrev && sdaBit;

endmodule

// File: rtl/cfg_bank_dp.sv
module cfg_bank_dp
  import cfg_bank_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter int PTR_W     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic                   sdaBit,
  output logic [7:0]             rxNext,
  output logic                   txNextBit,
  output logic                   txLoadMsb,
  output logic [NUM_BYTES*8-1:0] cfgBytes
);
  localparam logic [PTR_W-1:0] WR_LAST = PTR_W'(NUM_BYTES + 2);
  localparam logic [PTR_W-1:0] RD_LAST = PTR_W'(NUM_BYTES + 1);
  localparam logic [7:0]       COUNT_VAL = 8'(NUM_BYTES);

  logic [7:0]       bankQ [NUM_BYTES];
  logic [7:0]       rxShift;
  logic [7:0]       txShift;
  logic [7:0]       readSel;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  assign rxNext    = {rxShift[6:0], sdaBit};
  assign txNextBit = txShift[6];
  assign txLoadMsb = readSel[7];

  // Pointer 0 and 1 on writes are the discarded command and count bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BYTES; i++) bankQ[i] <= resetByte(i);
    end else if (strobe.storeByte) begin
      for (int i = 0; i < NUM_BYTES; i++)
        if (wrPtr == PTR_W'(i + 2)) bankQ[i] <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.clearPtrs) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.storeByte && wrPtr != WR_LAST) wrPtr <= wrPtr + 1'b1;
      if (strobe.loadTx && rdPtr != RD_LAST)    rdPtr <= rdPtr + 1'b1;
    end
  end

  // Read pointer 0 returns the count, 1..NUM_BYTES the bank, beyond that all ones
  always_comb begin
    readSel = 8'hFF;
    if (rdPtr == '0) readSel = COUNT_VAL;
    for (int i = 0; i < NUM_BYTES; i++)
      if (rdPtr == PTR_W'(i + 1)) readSel = bankQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
    end else begin
      if (strobe.sampleBit) rxShift <= rxNext;
      if (strobe.loadTx)       txShift <= readSel;
      else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_out
    assign cfgBytes[8*g +: 8] = bankQ[g];
  end

endmodule

// File: rtl/cfg_bank_ctrl.sv
module cfg_bank_ctrl
  import cfg_bank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startCond,
  input  logic       stopCond,
  input  logic       sdaBit,
  input  logic [7:0] rxNext,
  input  logic       txNextBit,
  input  logic       txLoadMsb,
  output dpStrobe_t  strobe,
  output logic       sdaLow,
  output busState_t  busState
);
  logic [2:0] bitCnt;
  logic       byteEnd;
  logic       isRead;
  logic       ackOk;
  logic       lastBit;

  assign lastBit = (bitCnt == 3'd7);

  always_comb begin
    strobe = '0;
    strobe.clearPtrs = startCond;
    if (!startCond && !stopCond) begin
      case (busState)
        ST_ADDR:     strobe.sampleBit = sclRise;
        ST_RX: begin
          strobe.sampleBit = sclRise;
          strobe.storeByte = sclRise && lastBit;
        end
        ST_ADDR_ACK: strobe.loadTx  = sclFall && isRead;
        ST_TX:       strobe.shiftTx = sclFall && !byteEnd;
        ST_TX_ACK:   strobe.loadTx  = sclFall && ackOk;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busState <= ST_IDLE;
      bitCnt   <= '0;
      byteEnd  <= 1'b0;
      isRead   <= 1'b0;
      ackOk    <= 1'b0;
      sdaLow   <= 1'b0;
    end else if (startCond) begin
      busState <= ST_ADDR;
      bitCnt   <= '0;
      byteEnd  <= 1'b0;
      ackOk    <= 1'b0;
      sdaLow   <= 1'b0;
    end else if (stopCond) begin
      busState <= ST_IDLE;
      byteEnd  <= 1'b0;
      ackOk    <= 1'b0;
      sdaLow   <= 1'b0;
    end else begin
      case (busState)
        ST_ADDR: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (lastBit) begin
              if (rxNext[7:1] == DEV_ADDR) begin
                isRead  <= rxNext[0];
                byteEnd <= 1'b1;
              end else begin
                busState <= ST_IDLE;
              end
            end
          end
          if (sclFall && byteEnd) begin
            busState <= ST_ADDR_ACK;
            sdaLow   <= 1'b1;
            byteEnd  <= 1'b0;
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              busState <= ST_TX;
              sdaLow   <= !txLoadMsb;
            end else begin
              busState <= ST_RX;
              sdaLow   <= 1'b0;
            end
          end
        end
        ST_RX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (lastBit) byteEnd <= 1'b1;
          end
          if (sclFall && byteEnd) begin
            busState <= ST_RX_ACK;
            sdaLow   <= 1'b1;
            byteEnd  <= 1'b0;
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            busState <= ST_RX;
            sdaLow   <= 1'b0;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (lastBit) byteEnd <= 1'b1;
          end
          if (sclFall) begin
            if (byteEnd) begin
              busState <= ST_TX_ACK;
              sdaLow   <= 1'b0;
              byteEnd  <= 1'b0;
            end else begin
              sdaLow <= !txNextBit;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            if (sdaBit) begin
              busState <= ST_IDLE;
              ackOk    <= 1'b0;
            end else begin
              ackOk <= 1'b1;
            end
          end
          if (sclFall && ackOk) begin
            busState <= ST_TX;
            bitCnt   <= '0;
            ackOk    <= 1'b0;
            sdaLow   <= !txLoadMsb;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_bank_target.sv
module cfg_bank_target
  import cfg_bank_pkg::*;
#(
  parameter int         NUM_BYTES   = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaDriveLow,
  output logic [NUM_BYTES*8-1:0] cfgBytes
);
  localparam int PTR_W = $clog2(NUM_BYTES + 3);

  logic      sclHigh;
  logic      sdaBit;
  logic      sclRise;
  logic      sclFall;
  logic      startCond;
  logic      stopCond;
  logic [7:0] rxNext;
  logic      txNextBit;
  logic      txLoadMsb;
  dpStrobe_t strobe;
  busState_t busState;

  cfg_bank_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclHigh(sclHigh), .sdaBit(sdaBit), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond)
  );

  cfg_bank_ctrl #(.DEV_ADDR(DEV_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .sdaBit(sdaBit),
    .rxNext(rxNext), .txNextBit(txNextBit), .txLoadMsb(txLoadMsb),
    .strobe(strobe), .sdaLow(sdaDriveLow), .busState(busState)
  );

  cfg_bank_dp #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit),
    .rxNext(rxNext), .txNextBit(txNextBit), .txLoadMsb(txLoadMsb),
    .cfgBytes(cfgBytes)
  );

endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk
  import cfg_bank_pkg::*;
#(
  parameter int NUM_BYTES = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclHigh,
  input logic                   startCond,
  input logic                   stopCond,
  input logic                   sdaDriveLow,
  input busState_t              busState,
  input logic                   storeByte,
  input logic [NUM_BYTES*8-1:0] cfgBytes
);

  // R8: the pull-down is taken only while SCL is low
  a_r8_pull_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !$past(sclHigh));

  // R8: the pull-down is released while SCL is low or on start/stop
  a_r8_release_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDriveLow) |-> (!$past(sclHigh) || $past(startCond) || $past(stopCond)));

  // R5: a transmitted bit does not move while SCL stays high
  a_r5_tx_bit_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_TX && sclHigh && $past(sclHigh)) |-> $stable(sdaDriveLow));

  // R1: no drive while the address is still being shifted in
  a_r1_addr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_ADDR) |-> !sdaDriveLow);

  // R6: an idle target never holds SDA
  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IDLE) |-> !sdaDriveLow);

  // R4: the acknowledge is held for the whole acknowledge slot
  a_r4_ack_held: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_RX_ACK) |-> sdaDriveLow);

  // R3: the bank only moves after a byte store strobe
  a_r3_bank_store_only: assert property (@(posedge clk) disable iff (!rstN)
    !$past(storeByte) |-> $stable(cfgBytes));

endmodule

bind cfg_bank_target cfg_bank_chk #(.NUM_BYTES(NUM_BYTES)) i_chk (
  .clk(clk), .rstN(rstN), .sclHigh(sclHigh), .startCond(startCond),
  .stopCond(stopCond), .sdaDriveLow(sdaDriveLow), .busState(busState),
  .storeByte(strobe.storeByte), .cfgBytes(cfgBytes)
);

// File: tb/test_cfg_bank_target.sv
module test_cfg_bank_target;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NB = 6;
  localparam int QT = 50;  // quarter SCL period in ns

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSdaLow = 1'b0;
  logic sdaDriveLow;
  logic sdaLine;
  logic [NB*8-1:0] cfgBytes;

  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      req;
  } expItem_t;
  expItem_t   expQ[$];
  logic [7:0] gotQ[$];
  logic [7:0] model[NB];

  assign sdaLine = !(mSdaLow || sdaDriveLow);

  always #2.5 clk = ~clk;

  cfg_bank_target i_cfg_bank_target (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .cfgBytes(cfgBytes)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each byte read back with the queued expectation
  initial begin
    forever begin
      logic [7:0] got;
      wait (gotQ.size() > 0);
      got = gotQ.pop_front();
      if (expQ.size() == 0) check(1'b0, "R5 unexpected read byte", got, 0);
      else begin
        expItem_t e;
        e = expQ.pop_front();
        check(got == e.val, e.req, got, e.val);
      end
    end
  end

  task automatic sendBit(input bit b);
    mSdaLow = !b; #QT;
    mScl = 1'b1;  #(2*QT);
    mScl = 1'b0;  #QT;
  endtask

  task automatic recvBit(output bit b);
    bit b1;
    mSdaLow = 1'b0; #QT;
    mScl = 1'b1;    #QT;
    b1 = sdaLine;   #QT;
    b = sdaLine;
    check(b1 == b, "R8 SDA steady while SCL high", b, b1);
    mScl = 1'b0;    #QT;
  endtask

  task automatic doStart();
    mSdaLow = 1'b0; #QT;
    mScl = 1'b1;    #QT;
    mSdaLow = 1'b1; #QT;
    mScl = 1'b0;    #QT;
  endtask

  task automatic doStop();
    mSdaLow = 1'b1; #QT;
    mScl = 1'b1;    #QT;
    mSdaLow = 1'b0; #QT;
  endtask

  task automatic writeByte(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    acked = !b;
  endtask

  task automatic readByte(input bit giveAck);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      bit b;
      recvBit(b);
      v[i] = b;
    end
    gotQ.push_back(v);
    sendBit(!giveAck);
  endtask

  // Address, command, count, then data; the model follows R2/R3/R4
  task automatic writeFrame(input logic [7:0] d[], input bit withStop);
    bit a;
    doStart();
    writeByte(8'hD2, a); check(a, "R1 write address ack", a, 1);
    writeByte(8'hA5, a); check(a, "R2 command byte ack", a, 1);
    writeByte(8'h3C, a); check(a, "R2 count byte ack", a, 1);
    foreach (d[i]) begin
      writeByte(d[i], a);
      check(a, "R4 data byte ack", a, 1);
      if (i < NB) model[i] = d[i];
    end
    if (withStop) doStop();
  endtask

  // Reads count plus nData bank bytes, NACK on the last one
  task automatic readFrame(input int nData, input string req);
    bit a;
    bit b;
    doStart();
    writeByte(8'hD3, a); check(a, "R1 read address ack", a, 1);
    expQ.push_back('{8'(NB), "R5 count byte"});
    for (int i = 0; i < nData; i++) expQ.push_back('{model[i], req});
    for (int i = 0; i <= nData; i++) readByte(i != nData);
    check(sdaDriveLow == 1'b0, "R6 SDA released after NACK", sdaDriveLow, 0);
    recvBit(b);
    check(b == 1'b1, "R6 no drive after NACK", b, 1);
    doStop();
    wait (gotQ.size() == 0);
  endtask

  task automatic cmpBank(input string req);
    for (int i = 0; i < NB; i++)
      check(cfgBytes[8*i +: 8] == model[i], req, cfgBytes[8*i +: 8], model[i]);
  endtask

  task automatic setDefaults();
    for (int i = 0; i < NB; i++) model[i] = (i == 0) ? 8'h0C : 8'hFF;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #500us;
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      finishRun();
    end
  end

  initial begin
    bit a;
    setDefaults();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R7: reset defaults, line released
    cmpBank("R7 reset default");
    check(sdaDriveLow == 1'b0, "R7 SDA released at reset", sdaDriveLow, 0);

    // R5: read back defaults, full length
    readFrame(NB, "R5 default read byte");

    // R2: command and count only, bank untouched
    writeFrame('{}, 1'b1);
    cmpBank("R2 command and count discarded");

    // R3/R4: full write plus two extra bytes
    writeFrame('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88}, 1'b1);
    cmpBank("R3 sequential store, R4 overflow discarded");
    readFrame(NB, "R5 read after full write");

    // R3: partial write stops after two bytes
    writeFrame('{8'h9A, 8'hBC}, 1'b1);
    cmpBank("R3 partial write");

    // R1: foreign addresses, no ack, bus ignored
    doStart();
    writeByte(8'hA0, a); check(!a, "R1 foreign address no ack", a, 0);
    writeByte(8'h00, a); check(!a, "R1 ignored until start", a, 0);
    doStop();
    doStart();
    writeByte(8'hD6, a); check(!a, "R1 near-miss address no ack", a, 0);
    doStop();
    cmpBank("R1 bank unchanged by foreign frame");

    // R9: repeated start restarts write at byte 0
    writeFrame('{8'h5A}, 1'b0);
    writeFrame('{8'hE1}, 1'b1);
    cmpBank("R9 restart rewinds write pointer");

    // R9: write then repeated start into a short read
    writeFrame('{8'h3C, 8'hC3}, 1'b0);
    readFrame(2, "R9 read after repeated start");

    // R6: NACK after the count byte only
    readFrame(0, "R6 early NACK");

    // R7: reset again brings defaults back
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    setDefaults();
    repeat (2) @(negedge clk);
    cmpBank("R7 defaults after second reset");

    done = 1'b1;
    finishRun();
  end

endmodule